// File: doc/BRIEF.md
# Multicast Tree Distribution Network

This block carries operands (input activations and filter weights) from the global buffer side of an accelerator to `N_LEAF` multiplier leaf slots. The path is a binary tree of routing switches. Each packet that enters at the root carries a data word and a destination bitmask with one bit per leaf. At every switch the mask is split into the half that covers the left subtree and the half that covers the right subtree. A child link carries the packet only when its half of the mask is nonzero, so a single packet can be a unicast, a multicast to any subset of leaves, or a broadcast. Links that lead only to leaves the packet does not address stay idle.

The parameter `FAT` sets the width of the tree links when the block is built. With `FAT=0` every link, the root included, carries one lane. With `FAT=1` a link above a subtree of S leaves carries S/2 lanes, with a minimum of one lane. The root then takes `N_LEAF/2` packets per cycle, one on each input lane. When more lanes need a link than the link has room for, the lower-numbered lanes win. Each leaf is a one-entry slot with two states:
- EMPTY moves to FULL on a load.
- FULL stays FULL while its multiplier holds `leaf_rdy` low, or when it is drained and refilled in the same cycle.
- FULL moves to EMPTY when it is drained without a refill.

A packet is accepted only when every leaf it addresses can take it, so no leaf ever receives part of a multicast. The leaves are also joined by a one-way chain from each leaf to its right-hand neighbour. Raising `fwd_sel[i]` makes leaf i load the operand last held by leaf i-1, with no new read from the buffer.

Top module: `mdt_dist_tree`

## Requirements
- R1: During and right after reset, every `leaf_vld` bit is 0 and `link_act` is 0 when no packet is presented.
- R2: `link_act` bit n is 1 in a cycle exactly when an accepted packet crosses the link into tree node n. Nodes use heap numbering: the root is node 1, the children of node n are 2n and 2n+1, and leaf i is node `N_LEAF+i`. Bit 0 is always 0.
- R3: An accepted packet is presented on `leaf_vld`/`leaf_data` at every leaf whose mask bit is set (mask bit i addresses leaf i), all in the cycle after acceptance. No other leaf is loaded by that packet.
- R4: A valid packet with an all-zero mask is accepted and discarded. It drives no link and changes no leaf.
- R5: With `FAT=1`, the link above a subtree of S leaves admits at most max(S/2,1) packets per cycle. Among the valid lanes that need a link, the lowest-numbered lanes are granted first. A lane that is refused sees `in_rdy` low, and lane k's packet is presented on `in_mask[k*N_LEAF +: N_LEAF]` and `in_data[k*DW +: DW]`.
- R6: A multicast packet takes one lane on each link it crosses, however many of its leaves lie below that link.
- R7: A packet stalls (`in_rdy` low, no link active) while any leaf it addresses is FULL with `leaf_rdy` low. Once it is accepted, all of its leaves load together.
- R8: A FULL leaf whose `leaf_rdy` is low keeps `leaf_vld` high and `leaf_data` unchanged.
- R9: When `fwd_sel[i]` is 1 for i>0 and leaf i can accept, leaf i loads the operand last held by leaf i-1. While `fwd_sel[i]` is 1, tree packets that address leaf i are refused.
- R10: `fwd_sel[0]` has no effect, and tree packets to leaf 0 are still accepted while it is set.
- R11: With `FAT=0` the root has a single lane, and a broadcast over that lane reaches all addressed leaves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_vld | input | LANES | Packet valid, one bit per root lane |
| in_mask | input | LANES*N_LEAF | Destination mask for each lane |
| in_data | input | LANES*DW | Operand word for each lane |
| in_rdy | output | LANES | Lane's packet can be accepted this cycle |
| fwd_sel | input | N_LEAF | Load leaf i from its left neighbour |
| leaf_rdy | input | N_LEAF | Multiplier consumes the leaf operand |
| leaf_vld | output | N_LEAF | Leaf holds an operand |
| leaf_data | output | N_LEAF*DW | Leaf operand words |
| link_act | output | 2*N_LEAF | Per-node link activity in heap numbering |

## Verification
The bench targets the following corner cases and what a faulty design would do in each:
- Two lanes meet on the single-lane link above a leaf pair. A faulty design would merge or corrupt the two words instead of refusing the higher lane.
- A multicast covers two leaves of one pair. A design that counts lanes per leaf rather than per link would refuse a packet that fits.
- A multicast addresses one leaf that is held FULL. A design without full-mask backpressure would load the free leaf early and later overwrite the held operand.
- A forward-select competes with a tree packet to the same leaf. A wrong design would drop one of the two operands.
- A zero-mask packet and the ignored forward select on leaf 0 are checked at the outputs to confirm that neither disturbs any link or leaf.

// File: rtl/mdt_pkg.sv
package mdt_pkg;

    typedef enum logic {
        L_EMPTY = 1'b0,
        L_FULL  = 1'b1
    } leaf_st_e;

    // Number of root lanes for a given leaf count and link mode.
    function automatic int root_lanes(int n_leaf, bit fat);
        if (!fat || n_leaf < 4) return 1;
        return n_leaf / 2;
    endfunction

    // Lanes on the link above a subtree of sub leaves.
    function automatic int link_cap(int sub, bit fat);
        if (!fat || sub < 2) return 1;
        return sub / 2;
    endfunction

endpackage

// File: rtl/mdt_leaf.sv
module mdt_leaf #(
    parameter int DW      = 16,
    parameter bit HAS_NBR = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tree_ld,
    input  logic [DW-1:0] tree_data,
    input  logic          fwd_sel,
    input  logic [DW-1:0] nbr_w,
    input  logic          leaf_rdy,
    output logic          free,
    output logic          vld,
    output logic [DW-1:0] dq
);
    import mdt_pkg::*;

    leaf_st_e      st_q, st_d;
    logic [DW-1:0] dq_q;
    logic          can_take, fwd_en, fwd_ld, load;

    // Next-state logic
    always_comb begin
        fwd_en   = HAS_NBR & fwd_sel;
        can_take = (st_q == L_EMPTY) | leaf_rdy;
        fwd_ld   = fwd_en & can_take;
        load     = tree_ld | fwd_ld;
        st_d     = st_q;
        unique case (st_q)
            L_EMPTY: st_d = load ? L_FULL : L_EMPTY;
            L_FULL:  st_d = (load || !leaf_rdy) ? L_FULL : L_EMPTY;
        endcase
    end

    // State and operand register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= L_EMPTY;
            dq_q <= '0;
        end else begin
            st_q <= st_d;
            if (load) dq_q <= tree_ld ? tree_data : nbr_w;
        end
    end

    // Outputs
    always_comb begin
        free = can_take & ~fwd_en;
        vld  = (st_q == L_FULL);
        dq   = dq_q;
    end

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && !leaf_rdy) |=> (vld && $stable(dq)));

    p_tree_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tree_ld |-> free);

    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tree_ld |=> (vld && dq == $past(tree_data)));

    p_fwd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_ld && !tree_ld) |=> (vld && dq == $past(nbr_w)));

endmodule

// File: rtl/mdt_route.sv
module mdt_route #(
    parameter int N     = 16,
    parameter int DW    = 16,
    parameter int LANES = 8,
    parameter bit FAT   = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LANES-1:0]   in_vld,
    input  logic [LANES*N-1:0] in_mask,
    input  logic [LANES*DW-1:0] in_data,
    input  logic [N-1:0]       leaf_free,
    output logic [LANES-1:0]   in_rdy,
    output logic [2*N-1:0]     link_act,
    output logic [N-1:0]       leaf_ld,
    output logic [N*DW-1:0]    leaf_dat
);
    localparam int NODES = 2 * N;
    localparam int CW    = $clog2(LANES + 1);

    logic [N-1:0]     nmask [NODES];
    logic [CW-1:0]    ncap  [NODES];
    logic [NODES-1:0] need  [LANES];
    logic [LANES-1:0] col   [NODES];
    logic [LANES-1:0] blk, gnt;
    logic [CW-1:0]    cnt;

    assign nmask[0] = '0;
    assign ncap[0]  = '0;

    // Per-node leaf coverage and lane capacity
    for (genvar n = 1; n < NODES; n++) begin : g_node
        localparam int D = $clog2(n + 1) - 1;
        localparam int S = N >> D;
        localparam int F = (n - (1 << D)) * S;
        assign nmask[n] = ({N{1'b1}} >> (N - S)) << F;
        assign ncap[n]  = CW'(mdt_pkg::link_cap(S, FAT));
    end

    // Mask split per node, then rank-based lane admission
    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            for (int n = 0; n < NODES; n++) begin
                need[k][n] = (n != 0) && in_vld[k] &&
                             (|(in_mask[k*N +: N] & nmask[n]));
            end
        end
        blk = '0;
        cnt = '0;
        for (int n = 1; n < NODES; n++) begin
            cnt = '0;
            for (int k = 0; k < LANES; k++) begin
                if (need[k][n]) begin
                    if (cnt >= ncap[n]) blk[k] = 1'b1;
                    cnt = cnt + CW'(1);
                end
            end
        end
        for (int i = 0; i < N; i++) begin
            for (int k = 0; k < LANES; k++) begin
                if (need[k][N+i] && !leaf_free[i]) blk[k] = 1'b1;
            end
        end
        in_rdy = ~blk;
        gnt    = in_vld & ~blk;
    end

    // Link activity and leaf delivery
    always_comb begin
        link_act = '0;
        leaf_dat = '0;
        for (int n = 0; n < NODES; n++) begin
            for (int k = 0; k < LANES; k++) begin
                col[n][k] = gnt[k] & need[k][n];
            end
            link_act[n] = |col[n];
        end
        for (int i = 0; i < N; i++) begin
            leaf_ld[i] = link_act[N+i];
            for (int k = 0; k < LANES; k++) begin
                if (col[N+i][k]) leaf_dat[i*DW +: DW] = leaf_dat[i*DW +: DW] | in_data[k*DW +: DW];
            end
        end
    end

    for (genvar n = 1; n < NODES; n++) begin : g_chk
        p_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(col[n]) <= int'(ncap[n]));
    end

    for (genvar i = 0; i < N; i++) begin : g_lchk
        p_leaf_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(col[N+i]));
    end

endmodule

// File: rtl/mdt_dist_tree.sv
module mdt_dist_tree #(
    parameter int  N_LEAF = 16,
    parameter int  DW     = 16,
    parameter bit  FAT    = 1'b1,
    localparam int LANES  = mdt_pkg::root_lanes(N_LEAF, FAT)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        in_vld,
    input  logic [LANES*N_LEAF-1:0] in_mask,
    input  logic [LANES*DW-1:0]     in_data,
    output logic [LANES-1:0]        in_rdy,
    input  logic [N_LEAF-1:0]       fwd_sel,
    input  logic [N_LEAF-1:0]       leaf_rdy,
    output logic [N_LEAF-1:0]       leaf_vld,
    output logic [N_LEAF*DW-1:0]    leaf_data,
    output logic [2*N_LEAF-1:0]     link_act
);
    logic [N_LEAF-1:0]    leaf_free, leaf_ld;
    logic [N_LEAF*DW-1:0] leaf_dat;

    mdt_route #(
        .N(N_LEAF), .DW(DW), .LANES(LANES), .FAT(FAT)
    ) u_route (
        .clk(clk), .rst_n(rst_n),
        .in_vld(in_vld), .in_mask(in_mask), .in_data(in_data),
        .leaf_free(leaf_free), .in_rdy(in_rdy), .link_act(link_act),
        .leaf_ld(leaf_ld), .leaf_dat(leaf_dat)
    );

    for (genvar i = 0; i < N_LEAF; i++) begin : g_leaf
        localparam int NB = (i == 0) ? 0 : i - 1;
        mdt_leaf #(
            .DW(DW), .HAS_NBR(i != 0)
        ) u_leaf (
            .clk(clk), .rst_n(rst_n),
            .tree_ld(leaf_ld[i]), .tree_data(leaf_dat[i*DW +: DW]),
            .fwd_sel(fwd_sel[i]),
            .nbr_w((i == 0) ? {DW{1'b0}} : leaf_data[NB*DW +: DW]),
            .leaf_rdy(leaf_rdy[i]), .free(leaf_free[i]),
            .vld(leaf_vld[i]), .dq(leaf_data[i*DW +: DW])
        );
    end

    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(in_vld & in_rdy)) |-> (link_act == '0));

    p_root_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|link_act[2*N_LEAF-1:N_LEAF]) |-> link_act[1]);

endmodule

// File: tb/tb_mdt_dist_tree.sv
module tb_mdt_dist_tree;
    localparam int N  = 16;
    localparam int DW = 16;
    localparam int L  = 8;

    typedef struct packed {
        logic [7:0]       vld;
        logic [7:0][15:0] m;
        logic [7:0]       rdy;
        logic [31:0]      link;
        logic [15:0]      lv;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        // broadcast on lane 0 (R3)
        '{vld:8'h01, m:{16'h0,16'h0,16'h0,16'h0,16'h0,16'h0,16'h0,16'hFFFF},
          rdy:8'hFF, link:32'hFFFFFFFE, lv:16'hFFFF},
        // eight unicasts, one per leaf pair (R5)
        '{vld:8'hFF, m:{16'h4000,16'h1000,16'h0400,16'h0100,16'h0040,16'h0010,16'h0004,16'h0001},
          rdy:8'hFF, link:32'h5555FFFE, lv:16'h5555},
        // two lanes meet on one leaf-pair link (R5)
        '{vld:8'h03, m:{16'h0,16'h0,16'h0,16'h0,16'h0,16'h0,16'h0002,16'h0001},
          rdy:8'hFD, link:32'h00010116, lv:16'h0001},
        // zero mask on lane 0 (R4), far unicast on lane 1
        '{vld:8'h03, m:{16'h0,16'h0,16'h0,16'h0,16'h0,16'h0,16'h8000,16'h0000},
          rdy:8'hFF, link:32'h8000808A, lv:16'h8000},
        // two multicasts into opposite halves
        '{vld:8'h03, m:{16'h0,16'h0,16'h0,16'h0,16'h0,16'h0,16'h0F00,16'h00F0},
          rdy:8'hFF, link:32'h0FF03C6E, lv:16'h0FF0},
        // multicast over one pair uses one lane (R6)
        '{vld:8'h06, m:{16'h0,16'h0,16'h0,16'h0,16'h0,16'h0400,16'h0300,16'h0},
          rdy:8'hFF, link:32'h0700304A, lv:16'h0700},
        // lanes 0 and 7 to the same leaf (R5)
        '{vld:8'h81, m:{16'h0010,16'h0,16'h0,16'h0,16'h0,16'h0,16'h0,16'h0010},
          rdy:8'h7F, link:32'h00100426, lv:16'h0010}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [L-1:0]    in_vld;
    logic [L*N-1:0]  in_mask;
    logic [L*DW-1:0] in_data;
    logic [L-1:0]    in_rdy;
    logic [N-1:0]    fwd_sel, leaf_rdy, leaf_vld;
    logic [N*DW-1:0] leaf_data;
    logic [2*N-1:0]  link_act;

    logic [0:0]      t_vld, t_rdy;
    logic [N-1:0]    t_mask, t_leaf_vld;
    logic [DW-1:0]   t_data;
    logic [N*DW-1:0] t_leaf_data;
    logic [2*N-1:0]  t_link;

    mdt_dist_tree #(.N_LEAF(N), .DW(DW), .FAT(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_mask(in_mask),
        .in_data(in_data), .in_rdy(in_rdy), .fwd_sel(fwd_sel),
        .leaf_rdy(leaf_rdy), .leaf_vld(leaf_vld), .leaf_data(leaf_data),
        .link_act(link_act)
    );

    mdt_dist_tree #(.N_LEAF(N), .DW(DW), .FAT(1'b0)) dut_thin (
        .clk(clk), .rst_n(rst_n), .in_vld(t_vld), .in_mask(t_mask),
        .in_data(t_data), .in_rdy(t_rdy), .fwd_sel({N{1'b0}}),
        .leaf_rdy({N{1'b1}}), .leaf_vld(t_leaf_vld), .leaf_data(t_leaf_data),
        .link_act(t_link)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_in();
        in_vld  = '0;
        in_mask = '0;
        in_data = '0;
    endtask

    function automatic logic [15:0] vdat(input int v, input int k);
        return 16'hD000 | 16'(v << 4) | 16'(k);
    endfunction

    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        clear_in();
        fwd_sel  = '0;
        leaf_rdy = '1;
        t_vld = '0; t_mask = '0; t_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 leaf_vld in reset", 64'(leaf_vld), 64'h0);
        check("R1 link_act in reset", 64'(link_act), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 leaf_vld after reset", 64'(leaf_vld), 64'h0);

        // Table walk, all leaves consuming each cycle
        for (int v = 0; v < NV; v++) begin
            in_vld  = VEC[v].vld;
            in_mask = VEC[v].m;
            for (int k = 0; k < L; k++) in_data[k*DW +: DW] = vdat(v, k);
            #1;
            check($sformatf("R5 in_rdy vec%0d", v), 64'(in_rdy), 64'(VEC[v].rdy));
            check($sformatf("R2 link_act vec%0d", v), 64'(link_act), 64'(VEC[v].link));
            @(negedge clk);
            check($sformatf("R3 leaf_vld vec%0d", v), 64'(leaf_vld), 64'(VEC[v].lv));
            for (int i = 0; i < N; i++) begin
                if (VEC[v].lv[i]) begin
                    int src = -1;
                    for (int k = L - 1; k >= 0; k--)
                        if (VEC[v].vld[k] && VEC[v].rdy[k] && VEC[v].m[k][i]) src = k;
                    check($sformatf("R3 leaf%0d data vec%0d", i, v),
                          64'(leaf_data[i*DW +: DW]), 64'(vdat(v, src)));
                end
            end
        end
        clear_in();
        @(negedge clk);
        check("R4 leaves drained", 64'(leaf_vld), 64'h0);

        // R8 / R7: held leaf blocks a multicast that includes it
        leaf_rdy[3] = 1'b0;
        in_vld[0] = 1'b1; in_mask[N-1:0] = 16'h0008; in_data[DW-1:0] = 16'h1111;
        @(negedge clk);
        in_mask[N-1:0] = 16'h0018; in_data[DW-1:0] = 16'h2222;
        #1;
        check("R7 stall in_rdy", 64'(in_rdy[0]), 64'h0);
        check("R7 stall links idle", 64'(link_act), 64'h0);
        @(negedge clk);
        check("R8 held leaf3 valid", 64'(leaf_vld[3]), 64'h1);
        check("R8 held leaf3 data", 64'(leaf_data[3*DW +: DW]), 64'h1111);
        check("R7 no partial load leaf4", 64'(leaf_vld[4]), 64'h0);
        leaf_rdy[3] = 1'b1;
        #1;
        check("R7 released in_rdy", 64'(in_rdy[0]), 64'h1);
        @(negedge clk);
        clear_in();
        check("R7 leaf3 new data", 64'(leaf_data[3*DW +: DW]), 64'h2222);
        check("R7 leaf4 loaded together", 64'({leaf_vld[4], leaf_data[4*DW +: DW]}), 64'h12222);

        // R9: forward from leaf5 into leaf6
        in_vld[0] = 1'b1; in_mask[N-1:0] = 16'h0020; in_data[DW-1:0] = 16'h5A5A;
        @(negedge clk);
        clear_in();
        fwd_sel[6] = 1'b1;
        in_vld[0] = 1'b1; in_mask[N-1:0] = 16'h0040; in_data[DW-1:0] = 16'h3333;
        #1;
        check("R9 tree refused at forwarding leaf", 64'(in_rdy[0]), 64'h0);
        @(negedge clk);
        fwd_sel[6] = 1'b0;
        clear_in();
        check("R9 leaf6 forwarded", 64'({leaf_vld[6], leaf_data[6*DW +: DW]}), 64'h15A5A);

        // R10: forward select on leaf 0 is ignored
        @(negedge clk);
        fwd_sel[0] = 1'b1;
        in_vld[0] = 1'b1; in_mask[N-1:0] = 16'h0001; in_data[DW-1:0] = 16'h4444;
        #1;
        check("R10 leaf0 tree accepted", 64'(in_rdy[0]), 64'h1);
        @(negedge clk);
        clear_in();
        fwd_sel[0] = 1'b0;
        check("R10 leaf0 data", 64'({leaf_vld[0], leaf_data[DW-1:0]}), 64'h14444);

        // R11: single-lane build, broadcast over half the leaves
        t_vld = 1'b1; t_mask = 16'h00FF; t_data = 16'h7777;
        #1;
        check("R11 thin in_rdy", 64'(t_rdy), 64'h1);
        check("R11 thin link_act", 64'(t_link), 64'h00FF0F36);
        @(negedge clk);
        t_vld = 1'b0;
        check("R11 thin leaf_vld", 64'(t_leaf_vld), 64'h00FF);
        check("R11 thin leaf7 data", 64'(t_leaf_data[7*DW +: DW]), 64'h7777);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule